// File: doc/BRIEF.md
# Centre-Aligned Up/Down PWM Generator

This block turns a system clock into a slow, centre-aligned pulse-width-modulated signal. A fixed prescaler produces one count step every `DIV` clocks. On each step a `CNT_W`-bit counter climbs from 0 to its top value, then descends back to 0, and repeats. The output flips whenever the counter lands on the active compare value. Because the counter passes each interior value once on the way up and once on the way down, the high phase sits symmetrically around the top of the ramp.

Software or a neighbouring block offers a new compare value with a one-clock load strobe. The value waits in a shadow register and takes effect only when the counter reaches its top, so a period never mixes two compare values on the same slope. A one-clock pulse marks each return of the counter to 0. This lets a consumer count periods or align other events to the waveform.

Top module: `dpwm_gen`

## Requirements
- R1: With MAX = 2^CNT_W − 1 (default 1023), the count steps up from 0 to MAX and then down to 0, turning at both ends without repeating them. One period is 2·MAX steps (2046 by default).
- R2: While `en` is high the count advances exactly once every `DIV` clocks (default 256). The first step lands `DIV` clocks after `en` rises. While `en` is low the prescaler, count, direction and `pwm_out` all hold.
- R3: `pwm_out` inverts in the same clock in which `count` takes a value equal to the active compare value, on the rising slope and on the falling slope. It changes at no other time.
- R4: After reset `count` is 0 and heading up, `pwm_out` is 0, `period_pulse` is 0, and both the shadow and the active compare hold `CMP_RST` (default 512).
- R5: A clock with `cmp_ld` high copies `cmp_in` into the shadow. The shadow becomes active in the clock the count reaches MAX, and the match test at MAX already uses the new value. Until then the old value governs.
- R6: An active compare of 0 or of MAX yields exactly one inversion per period, at that end point.
- R7: `period_pulse` is high for exactly one clock each time the count reaches 0, and at no other time.
- R8: With an interior compare C held through a period that starts low, `pwm_out` is high for 2·(MAX − C) of the 2·MAX steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for prescaler and counter |
| cmp_in | input | CNT_W | New compare value |
| cmp_ld | input | 1 | One-clock strobe that writes `cmp_in` into the shadow |
| pwm_out | output | 1 | Centre-aligned PWM output |
| count | output | CNT_W | Present counter value |
| period_pulse | output | 1 | One-clock marker when the count reaches 0 |

## Verification
`count`, `pwm_out` and `period_pulse` all change on the same clock edge, which is the `DIV`-th edge after the previous step. A compare load is captured one edge after the strobe and first matters at the next arrival at MAX. The bench drives inputs and samples outputs on falling edges. It waits exactly `DIV` falling edges per step before it compares count, output and pulse against its own step model. One falling edge into each step it also confirms that the pulse has already dropped. The bench uses a 4-bit counter and a prescaler of 4, so several full periods fit in a short run.

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
  parameter int CNT_W   = 10,
  parameter int DIV     = 256,
  parameter int CMP_RST = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             cmp_ld,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count,
  output logic             period_pulse
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [DW-1:0]    div_q;
  logic             up_q;
  logic [CNT_W-1:0] shd_q, act_q, cnt_d, cmp_eff;
  logic             tick, up_d;

  assign tick    = en && (div_q == DW'(DIV - 1));
  assign cnt_d   = up_q ? count + 1'b1 : count - 1'b1;
  assign up_d    = (cnt_d == TOP) ? 1'b0 : (cnt_d == '0) ? 1'b1 : up_q;
  assign cmp_eff = (cnt_d == TOP) ? shd_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  div_q <= '0;
    else if (en) div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shd_q <= CNT_W'(CMP_RST);
    else if (cmp_ld) shd_q <= cmp_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count        <= '0;
      up_q         <= 1'b1;
      act_q        <= CNT_W'(CMP_RST);
      pwm_out      <= 1'b0;
      period_pulse <= 1'b0;
    end else begin
      period_pulse <= tick && (cnt_d == '0);
      if (tick) begin
        count <= cnt_d;
        up_q  <= up_d;
        if (cnt_d == TOP)     act_q   <= shd_q;
        if (cnt_d == cmp_eff) pwm_out <= ~pwm_out;
      end
    end
  end
endmodule

module dpwm_gen_chk #(
  parameter int CNT_W = 10,
  parameter int DIV   = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_out,
  input logic [CNT_W-1:0] count,
  input logic             period_pulse
);
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1) || count == CNT_W'($past(count) - 1'b1)));

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count) && $stable(pwm_out)));

  a_r3_toggle_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_out) |-> !$stable(count));

  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> (count == '0));

  a_r7_pulse_zero_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(count) && count == '0) |-> period_pulse);

  generate
    if (DIV > 1) begin : g_one
      a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |=> !period_pulse);
    end
  endgenerate
endmodule

bind dpwm_gen dpwm_gen_chk #(.CNT_W(CNT_W), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out),
  .count(count), .period_pulse(period_pulse));

// File: tb/dpwm_gen_tb.sv
module dpwm_gen_tb;
  localparam int W = 4, DIV = 4, CRST = 8;
  localparam int MAX = (1 << W) - 1, PER = 2 * MAX;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cmp_ld = 1'b0, pwm_out, period_pulse;
  logic [W-1:0] cmp_in = '0, count;
  int n_run = 0, n_fail = 0;
  int exp_cnt = 0, tog_n = 0, high_n = 0, pulse_n = 0;
  bit exp_up = 1'b1, prev_pwm = 1'b0;
  int tog_pos[4];

  always #4 clk = ~clk;

  dpwm_gen #(.CNT_W(W), .DIV(DIV), .CMP_RST(CRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp_in(cmp_in), .cmp_ld(cmp_ld),
    .pwm_out(pwm_out), .count(count), .period_pulse(period_pulse));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit ld, input int v);
    cmp_in = W'(v); cmp_ld = ld;
    @(negedge clk);
    cmp_ld = 1'b0;
    chk(period_pulse == 1'b0, "R7 pulse width", period_pulse, 0);
    repeat (DIV - 1) @(negedge clk);
    if (exp_up) begin exp_cnt++; if (exp_cnt == MAX) exp_up = 1'b0; end
    else        begin exp_cnt--; if (exp_cnt == 0)   exp_up = 1'b1; end
    chk(int'(count) == exp_cnt, "R1/R2 count", count, exp_cnt);
    chk(period_pulse == (exp_cnt == 0), "R7 pulse", period_pulse, exp_cnt == 0);
    if (pwm_out != prev_pwm) begin
      if (tog_n < 4) tog_pos[tog_n] = int'(count);
      tog_n++;
    end
    prev_pwm = pwm_out;
    if (pwm_out) high_n++;
    if (period_pulse) pulse_n++;
  endtask

  task automatic period(input int ld_step, input int v);
    tog_n = 0; high_n = 0; pulse_n = 0;
    for (int s = 0; s < PER; s++) step(s == ld_step, v);
    chk(pulse_n == 1, "R7 pulses per period", pulse_n, 1);
  endtask

  task automatic t_reset;
    chk(count == '0, "R4 count", count, 0);
    chk(pwm_out == 1'b0, "R4 pwm", pwm_out, 0);
    chk(period_pulse == 1'b0, "R4 pulse", period_pulse, 0);
  endtask

  task automatic t_prescale;
    en = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    chk(count == '0, "R2 no early step", count, 0);
    @(negedge clk);
    chk(count == W'(1), "R2 first step", count, 1);
    exp_cnt = 1;
    for (int s = 1; s < PER; s++) step(1'b0, 0);
  endtask

  task automatic t_default;
    period(-1, 0);
    chk(tog_n == 2, "R3 toggles", tog_n, 2);
    chk(tog_pos[0] == CRST && tog_pos[1] == CRST, "R3 toggle place", tog_pos[1], CRST);
    chk(high_n == 2 * (MAX - CRST), "R8 high steps", high_n, 2 * (MAX - CRST));
  endtask

  task automatic t_shadow;
    period(2, 3);
    chk(tog_n == 2 && tog_pos[0] == CRST, "R5 old value on rise", tog_pos[0], CRST);
    chk(tog_pos[1] == 3, "R5 new value on fall", tog_pos[1], 3);
    period(-1, 0);
    chk(tog_n == 2 && tog_pos[0] == 3, "R5 new value next rise", tog_pos[0], 3);
    chk(high_n == 2 * (MAX - 3), "R8 high steps C=3", high_n, 2 * (MAX - 3));
  endtask

  task automatic t_ends;
    period(0, 0);
    chk(tog_n == 2 && tog_pos[1] == 0, "R5 zero becomes active at top", tog_pos[1], 0);
    period(-1, 0);
    chk(tog_n == 1, "R6 compare 0 toggles", tog_n, 1);
    chk(tog_pos[0] == 0, "R6 compare 0 place", tog_pos[0], 0);
    period(0, MAX);
    chk(tog_n == 1 && tog_pos[0] == MAX, "R5 top match uses new value", tog_pos[0], MAX);
    period(-1, 0);
    chk(tog_n == 1, "R6 compare MAX toggles", tog_n, 1);
    chk(tog_pos[0] == MAX, "R6 compare MAX place", tog_pos[0], MAX);
  endtask

  task automatic t_hold;
    step(1'b0, 0); step(1'b0, 0); step(1'b0, 0);
    en = 1'b0;
    repeat (5 * DIV) @(negedge clk);
    chk(int'(count) == exp_cnt, "R2 hold count", count, exp_cnt);
    chk(pwm_out == prev_pwm, "R2 hold pwm", pwm_out, prev_pwm);
    en = 1'b1;
    step(1'b0, 0);
    chk(1'b1, "R2 resume", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale;
    t_default;
    t_shadow;
    t_ends;
    t_hold;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule